// File: doc/BRIEF.md
# Program Counter and Return-Stack Sequencer

This block owns the program counter of a small 8-bit accumulator controller whose instructions are 13 bits wide. On every clock it chooses the next address from the decoded instruction class. The choices are a plain increment, a conditional skip requested by the arithmetic unit, a return taken from a hardware return stack, a return that also turns interrupts on, and a computed table jump that adds the accumulator into the low byte of the program counter.

Skips, returns and table jumps all take two cycles. The block raises a stall indicator for the second cycle, and in that cycle it ignores every instruction input. Calls reach the block as a push request together with the return address to be saved. The return stack is a fixed ring of entries. Too many pushes overwrite the oldest entry, and popping past empty simply wraps around the ring.

Top module: `pcseq_core`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets pc to 0, int_en to 0 and stall to 0, and makes every stack entry read as 0, so a return right after reset goes to address 0.
- R2: With stall low and op_class = 0 (step) and skip_req low, pc becomes pc+1 modulo 2^11 at the next edge and stall stays low; 0x7FF advances to 0x000.
- R3: With stall low, op_class = 0 and skip_req high, pc becomes pc+1 and stall goes high at the next edge; at the edge after that pc advances by 1 again and stall falls, for +2 over two cycles.
- R4: With stall low and op_class = 1 (return), pc is loaded with the most recently pushed address at the next edge, stall is high for exactly one cycle, pc holds during that cycle and int_en is unchanged.
- R5: op_class = 2 (return with interrupt enable) behaves as R4 and also sets int_en at the same edge; int_en then stays high until reset.
- R6: With stall low and op_class = 3 (table), pc bits 7:0 become (pc[7:0] + acc) modulo 256 with no carry into bit 8, pc bits 10:8 are unchanged, and stall is high for one cycle with pc held.
- R7: The return stack is last-in first-out with 8 entries; a ninth push overwrites the oldest entry, so after ten pushes the first eight pops return the last eight pushed addresses newest first.
- R8: A pop with no saved entries left continues around the 8-entry ring without error, returning the newest surviving entries again in the same order.
- R9: While stall is high, op_class, skip_req, acc, push_req and push_addr have no effect on pc, int_en or the stack.
- R10: push_req saves push_addr only in a cycle with stall low and op_class = 0; skip_req matters only with op_class = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_class | input | 2 | Decoded class: 0 step, 1 return, 2 return with interrupt enable, 3 table |
| skip_req | input | 1 | Skip request from the arithmetic unit |
| acc | input | 8 | Accumulator value for table jumps |
| push_req | input | 1 | Save push_addr on the return stack |
| push_addr | input | 11 | Return address to save |
| pc | output | 11 | Program counter |
| int_en | output | 1 | Global interrupt enable |
| stall | output | 1 | High in the second cycle of a two-cycle instruction |

## Verification
The bench builds the block with its default parameters: an 11-bit counter, an 8-bit accumulator, an 8-entry stack and the pointer-addressed stack variant. With these values a table jump starting at 0x7F0 shows the upper bits held while the low byte wraps. Ten pushes overrun the stack, ten pops run past empty, and a handful of steps from 0x7FE wrap the counter. The reference model keeps the stack as a rotating queue, so it shares no structure with either stack variant.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
   typedef enum logic [1:0] {
      OP_STEP      = 2'd0,
      OP_RETURN    = 2'd1,
      OP_RETURN_IE = 2'd2,
      OP_TABLE     = 2'd3
   } op_e;
endpackage

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
   parameter int W     = 11,
   parameter int DEPTH = 8,
   parameter bit RING  = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] top
);
   localparam int SP_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pcseq_stack: DEPTH must be a power of two of at least 2");
   end

   if (RING) begin : g_ring
      logic [W-1:0] ent [DEPTH];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
         end else if (push) begin
            ent[0] <= din;
            for (int i = 1; i < DEPTH; i++) ent[i] <= ent[i-1];
         end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) ent[i] <= ent[i+1];
            ent[DEPTH-1] <= ent[0];
         end
      end
      assign top = ent[0];
   end else begin : g_ptr
      logic [W-1:0]    mem [DEPTH];
      logic [SP_W-1:0] sp;
      logic [SP_W-1:0] sp_m1;
      assign sp_m1 = sp - 1'b1;
      always_ff @(posedge clk) begin
         if (rst) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (push) begin
            mem[sp] <= din;
            sp      <= sp + 1'b1;
         end else if (pop) begin
            sp <= sp_m1;
         end
      end
      assign top = mem[sp_m1];
   end

   AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(push && pop)); // R10
endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
   import pcseq_pkg::*;
#(
   parameter int PC_W  = 11,
   parameter int ACC_W = 8
) (
   input  logic [PC_W-1:0]  pc,
   input  logic             stall,
   input  logic             adv,
   input  logic [1:0]       op_class,
   input  logic             skip_req,
   input  logic [ACC_W-1:0] acc,
   input  logic             push_req,
   input  logic [PC_W-1:0]  stk_top,
   output logic [PC_W-1:0]  pc_d,
   output logic             stall_d,
   output logic             adv_d,
   output logic             set_ie,
   output logic             do_push,
   output logic             do_pop
);
   op_e op;
   assign op = op_e'(op_class);

   always_comb begin
      pc_d    = pc;
      stall_d = 1'b0;
      adv_d   = 1'b0;
      set_ie  = 1'b0;
      do_push = 1'b0;
      do_pop  = 1'b0;
      if (stall) begin
         if (adv) pc_d = pc + 1'b1;
      end else begin
         unique case (op)
            OP_STEP: begin
               do_push = push_req;
               pc_d    = pc + 1'b1;
               stall_d = skip_req;
               adv_d   = skip_req;
            end
            OP_RETURN, OP_RETURN_IE: begin
               do_pop  = 1'b1;
               pc_d    = stk_top;
               stall_d = 1'b1;
               set_ie  = (op == OP_RETURN_IE);
            end
            OP_TABLE: begin
               pc_d    = {pc[PC_W-1:ACC_W], pc[ACC_W-1:0] + acc};
               stall_d = 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pcseq_core.sv
module pcseq_core
   import pcseq_pkg::*;
#(
   parameter int PC_W      = 11,
   parameter int ACC_W     = 8,
   parameter int STK_DEPTH = 8,
   parameter bit STK_RING  = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       op_class,
   input  logic             skip_req,
   input  logic [ACC_W-1:0] acc,
   input  logic             push_req,
   input  logic [PC_W-1:0]  push_addr,
   output logic [PC_W-1:0]  pc,
   output logic             int_en,
   output logic             stall
);
   if (ACC_W < 1 || ACC_W >= PC_W) begin : g_bad_width
      $error("pcseq_core: ACC_W must be below PC_W");
   end

   logic [PC_W-1:0] pc_q, pc_d, stk_top;
   logic            ie_q, stall_q, adv_q;
   logic            stall_d, adv_d, set_ie, do_push, do_pop;

   pcseq_next #(.PC_W(PC_W), .ACC_W(ACC_W)) u_next (
      .pc(pc_q), .stall(stall_q), .adv(adv_q), .op_class(op_class),
      .skip_req(skip_req), .acc(acc), .push_req(push_req), .stk_top(stk_top),
      .pc_d(pc_d), .stall_d(stall_d), .adv_d(adv_d), .set_ie(set_ie),
      .do_push(do_push), .do_pop(do_pop)
   );

   pcseq_stack #(.W(PC_W), .DEPTH(STK_DEPTH), .RING(STK_RING)) u_stk (
      .clk(clk), .rst(rst), .push(do_push), .pop(do_pop),
      .din(push_addr), .top(stk_top)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q    <= '0;
         ie_q    <= 1'b0;
         stall_q <= 1'b0;
         adv_q   <= 1'b0;
      end else begin
         pc_q    <= pc_d;
         stall_q <= stall_d;
         adv_q   <= adv_d;
         if (set_ie) ie_q <= 1'b1;
      end
   end

   assign pc     = pc_q;
   assign int_en = ie_q;
   assign stall  = stall_q;

   AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
      (!stall && op_class == OP_STEP && !skip_req) |=> (pc == $past(pc) + 1'b1) && !stall); // R2
   AST_SKIP_STALL: assert property (@(posedge clk) disable iff (rst)
      (!stall && op_class == OP_STEP && skip_req) |=> stall); // R3
   AST_RETURN_STALL: assert property (@(posedge clk) disable iff (rst)
      (!stall && (op_class == OP_RETURN || op_class == OP_RETURN_IE)) |=> stall); // R4
   AST_IE_STICKY: assert property (@(posedge clk) disable iff (rst)
      int_en |=> int_en); // R5
   AST_TABLE_HI: assert property (@(posedge clk) disable iff (rst)
      (!stall && op_class == OP_TABLE) |=> pc[PC_W-1:ACC_W] == $past(pc[PC_W-1:ACC_W])); // R6
   AST_STALL_ONE: assert property (@(posedge clk) disable iff (rst)
      stall |=> !stall); // R9
endmodule

// File: tb/sim_pcseq_core.sv
`timescale 1ns/100ps
module sim_pcseq_core;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  op_class = 2'd0;
   logic        skip_req = 1'b0;
   logic [7:0]  acc = 8'd0;
   logic        push_req = 1'b0;
   logic [10:0] push_addr = 11'd0;
   logic [10:0] pc;
   logic        int_en, stall;

   always #2.5 clk = ~clk;

   pcseq_core u0 (
      .clk(clk), .rst(rst), .op_class(op_class), .skip_req(skip_req),
      .acc(acc), .push_req(push_req), .push_addr(push_addr),
      .pc(pc), .int_en(int_en), .stall(stall)
   );

   int checks = 0;
   int errors = 0;

   // reference model: stack kept as a rotating queue, front = newest
   int m_pc, m_ie, m_st, m_adv;
   int q[$];

   task automatic model(input int r, input int op, input int sk, input int a,
                        input int pu, input int pa);
      int v;
      if (r != 0) begin
         m_pc = 0; m_ie = 0; m_st = 0; m_adv = 0;
         q = {};
         for (int i = 0; i < 8; i++) q.push_back(0);
      end else if (m_st != 0) begin
         if (m_adv != 0) m_pc = (m_pc + 1) % 2048;
         m_st = 0; m_adv = 0;
      end else if (op == 0) begin
         if (pu != 0) begin q.push_front(pa); v = q.pop_back(); end
         m_pc = (m_pc + 1) % 2048;
         m_st = sk; m_adv = sk;
      end else if (op == 3) begin
         m_pc = (m_pc / 256) * 256 + ((m_pc + a) % 256);
         m_st = 1; m_adv = 0;
      end else begin
         v = q.pop_front(); q.push_back(v);
         m_pc = v; m_st = 1; m_adv = 0;
         if (op == 2) m_ie = 1;
      end
   endtask

   task automatic step(input string req, input int r, input int op, input int sk,
                       input int a, input int pu, input int pa);
      @(negedge clk);
      rst = (r != 0); op_class = op[1:0]; skip_req = (sk != 0);
      acc = a[7:0]; push_req = (pu != 0); push_addr = pa[10:0];
      @(posedge clk);
      model(r, op, sk, a, pu, pa);
      #1;
      checks++;
      if (pc !== m_pc[10:0] || int_en !== (m_ie != 0) || stall !== (m_st != 0)) begin
         errors++;
         $display("FAIL %s: pc=%h ie=%b stall=%b expected pc=%h ie=%0d stall=%0d",
                  req, pc, int_en, stall, m_pc[10:0], m_ie, m_st);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, expected end of sequence");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      step("R1 reset", 1, 0, 0, 0, 0, 0);
      step("R1 reset", 1, 2, 1, 9, 1, 5);
      for (int i = 0; i < 5; i++) step("R2 step", 0, 0, 0, 0, 0, 0);
      // return on empty stack after reset lands on 0
      step("R1 empty return", 0, 1, 0, 0, 0, 0);
      step("R9 stall ignores push", 0, 0, 1, 0, 1, 'h3AA);
      step("R2 step", 0, 0, 0, 0, 1, 'h123);
      step("R7 push", 0, 0, 0, 0, 1, 'h456);
      step("R3 skip first", 0, 0, 1, 0, 0, 0);
      step("R3 skip second", 0, 1, 0, 0, 1, 'h111);
      step("R10 skip with table", 0, 3, 1, 'h10, 0, 0);
      step("R6 table stall", 0, 0, 0, 0, 0, 0);
      step("R4 return", 0, 1, 0, 0, 0, 0);
      step("R9 stall ignores table", 0, 3, 1, 'h44, 1, 'h222);
      step("R5 return ie", 0, 2, 0, 0, 0, 0);
      step("R5 stall", 0, 0, 0, 0, 0, 0);
      step("R5 ie holds", 0, 0, 0, 0, 0, 0);
      // table jump from 0x7F0: low byte wraps, bits 10:8 kept
      step("R6 push", 0, 0, 0, 0, 1, 'h7F0);
      step("R4 return", 0, 1, 0, 0, 0, 0);
      step("R4 stall", 0, 0, 0, 0, 0, 0);
      step("R6 table wrap", 0, 3, 0, 'h25, 0, 0);
      step("R6 table stall", 0, 0, 0, 0, 0, 0);
      step("R6 table zero", 0, 3, 0, 0, 0, 0);
      step("R6 table stall", 0, 0, 0, 0, 0, 0);
      // push ignored with a return
      step("R10 push", 0, 0, 0, 0, 1, 'h0AB);
      step("R10 return with push", 0, 1, 0, 0, 1, 'h0CD);
      step("R10 stall", 0, 0, 0, 0, 0, 0);
      step("R10 return below", 0, 1, 0, 0, 0, 0);
      step("R10 stall", 0, 0, 0, 0, 0, 0);
      // overrun and underrun
      for (int i = 0; i < 10; i++) step("R7 push", 0, 0, 0, 0, 1, 'h100 + i);
      for (int i = 0; i < 8; i++) begin
         step("R7 pop", 0, 1, 0, 0, 0, 0);
         step("R7 stall", 0, 0, 0, 0, 0, 0);
      end
      for (int i = 0; i < 2; i++) begin
         step("R8 pop past empty", 0, 1, 0, 0, 0, 0);
         step("R8 stall", 0, 0, 0, 0, 0, 0);
      end
      // counter wrap
      step("R2 push", 0, 0, 0, 0, 1, 'h7FE);
      step("R4 return", 0, 1, 0, 0, 0, 0);
      step("R4 stall", 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 3; i++) step("R2 wrap", 0, 0, 0, 0, 0, 0);
      step("R3 skip at 0x001", 0, 0, 1, 0, 0, 0);
      step("R3 skip second", 0, 0, 0, 0, 0, 0);
      step("R1 reset again", 1, 0, 0, 0, 0, 0);
      step("R1 ie cleared", 0, 0, 0, 0, 0, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule